// File: doc/BRIEF.md
# Cascaded Interrupt Controller Register Front-End

This block is the register side of two chained legacy-style interrupt controllers. A primary controller owns request lines 0 to 7. A secondary controller owns lines 8 to 15 and reports through line 2 of the primary. Each controller has a byte-wide command port and a byte-wide data port on a small synchronous bus. Each also has its own byte-wide trigger-type port. Software uses the command port for two things: to start a short initialization sequence on the data port, which programs the vector base, and to retire the in-service request with an end-of-interrupt command. Outside an initialization sequence, the data port reads and writes the interrupt mask.

The block drives the mask, trigger-type and in-service vectors to the arbitration and acknowledge logic downstream. That logic marks requests as in service through a set vector. A combinational port turns a request index into the vector number given by the programmed bases.

Top module: `cpic_regif`

## Requirements
- R1: After reset, every mask bit is 1, every trigger-type bit is 0, no request is in service, no initialization is in progress, and both vector bases are 0xFF. Index 0 then translates to 0xFF, and index 1 translates to 0x00 because the 8-bit sum wraps.
- R2: A command-port write with bit 4 set starts initialization of that controller. In the following cycle its mask byte is 0x00 and its `init_busy` bit is 1.
- R3: During initialization, the controller takes data-port writes in order. The first is the vector base, with its low 3 bits forced to 0. A cascade word follows only when bit 1 of the starting command was 0. A mode word follows only when bit 0 of the starting command was 1. After the last expected word, `init_busy` drops and data-port writes load the mask again.
- R4: A data-port read while initialization is unfinished returns the current mask, which is 0x00.
- R5: Port select codes are: 0 primary command, 1 primary data, 2 secondary command, 3 secondary data, 4 primary trigger, 5 secondary trigger. Read data appears on `bus_rdata` in the cycle after `bus_rd` and holds until the next read. An idle data-port write replaces the mask byte.
- R6: The trigger ports read and write an 8-bit trigger-type register per controller, where a 1 means level-triggered. The registers drive `irq_level`, with the primary in the low byte.
- R7: For an index of 0 to 7, the vector is the primary base plus the index. For an index of 8 to 15, it is the secondary base plus the index minus 8.
- R8: An index above 15 raises `xlat_invalid` and returns vector 0.
- R9: A 1 on `svc_set` marks that request in service on the next edge. A command-port read returns that controller's in-service byte.
- R10: A command write of 0x20 clears only the lowest-numbered in-service bit of the addressed controller. With nothing in service, it has no effect.
- R11: A command write whose bit 4 is 0 and which is not 0x20 changes neither the mask nor the in-service bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 3 | Port select code |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| svc_set | input | 16 | Marks requests in service |
| in_service | output | 16 | In-service bits, primary in low byte |
| irq_mask | output | 16 | Mask bits, 1 disables the line |
| irq_level | output | 16 | Trigger type, 1 means level |
| init_busy | output | 2 | Initialization in progress per controller |
| xlat_idx | input | 5 | Request index to translate |
| xlat_vec | output | 8 | Translated vector |
| xlat_invalid | output | 1 | Index out of range |

## Verification
The initialization sequence is run with three starting commands: cascade with mode word, single with mode word, and single alone. A mask read after each one shows how many data writes the sequencer consumed. A mask read taken in the middle of a sequence separates "mask cleared and held" from "write landed in the mask". Translation is probed at both ends of each controller's range and at the wrap from the reset bases, which catches a wrong half-select or a missing subtract of 8. End-of-interrupt is driven with two in-service bits per controller, then with an empty controller, which exposes clearing the wrong bit, clearing in both controllers, or clearing everything.

// File: rtl/cpic_pkg.sv
// Shared constants and types for the cascaded interrupt controller front-end.
// Assumes an 8-line controller per byte; port codes are fixed by software use.
package cpic_pkg;
    localparam int DATA_W   = 8;
    localparam int SEL_W    = 3;
    localparam int IDX_W    = 5;
    localparam int N_CTRL   = 2;

    localparam logic [SEL_W-1:0] PSEL_MCMD  = 3'd0;
    localparam logic [SEL_W-1:0] PSEL_MDATA = 3'd1;
    localparam logic [SEL_W-1:0] PSEL_SCMD  = 3'd2;
    localparam logic [SEL_W-1:0] PSEL_SDATA = 3'd3;
    localparam logic [SEL_W-1:0] PSEL_MTRIG = 3'd4;
    localparam logic [SEL_W-1:0] PSEL_STRIG = 3'd5;

    localparam logic [DATA_W-1:0] CMD_EOI = 8'h20;
    localparam int START_BIT  = 4;
    localparam int SINGLE_BIT = 1;
    localparam int MODEW_BIT  = 0;

    typedef enum logic [1:0] {
        INIT_IDLE = 2'd0,
        INIT_BASE = 2'd1,
        INIT_CASC = 2'd2,
        INIT_MODE = 2'd3
    } init_st_e;
endpackage

// File: rtl/cpic_ctrl.sv
// One controller: init-word sequencer, mask, trigger-type and in-service
// registers, and the end-of-interrupt command.
// Assumes the strobes are already decoded for this controller and are
// mutually exclusive; svc_set comes from the acknowledge logic.
module cpic_ctrl #(
    parameter int W = cpic_pkg::DATA_W,
    parameter logic [W-1:0] BASE_RST = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cmd_we,
    input  logic         data_we,
    input  logic         trig_we,
    input  logic [W-1:0] wdata,
    input  logic [W-1:0] svc_set,
    output logic [W-1:0] mask_q,
    output logic [W-1:0] trig_q,
    output logic [W-1:0] isr_q,
    output logic [W-1:0] base_q,
    output logic         busy
);
    import cpic_pkg::*;

    localparam int ALIGN = $clog2(W);

    init_st_e    st_q;
    logic        need_casc_q;
    logic        need_mode_q;
    logic        is_start;
    logic        is_eoi;
    logic [W-1:0] eoi_clr;
    init_st_e    st_after_base;
    init_st_e    st_after_casc;

    // Decode command writes and pick the next init stage.
    always_comb begin
        is_start      = cmd_we && wdata[START_BIT];
        is_eoi        = cmd_we && (wdata == CMD_EOI);
        eoi_clr       = is_eoi ? (isr_q & (~isr_q + 1'b1)) : '0;
        st_after_casc = need_mode_q ? INIT_MODE : INIT_IDLE;
        st_after_base = need_casc_q ? INIT_CASC : st_after_casc;
    end

    // Init-word sequencer: which meaning the next data write carries.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q        <= INIT_IDLE;
            need_casc_q <= 1'b0;
            need_mode_q <= 1'b0;
        end else if (is_start) begin
            st_q        <= INIT_BASE;
            need_casc_q <= !wdata[SINGLE_BIT];
            need_mode_q <= wdata[MODEW_BIT];
        end else if (data_we) begin
            case (st_q)
                INIT_BASE: st_q <= st_after_base;
                INIT_CASC: st_q <= st_after_casc;
                INIT_MODE: st_q <= INIT_IDLE;
                default:   st_q <= INIT_IDLE;
            endcase
        end
    end

    // Vector base, aligned to a whole controller's worth of lines.
    always_ff @(posedge clk) begin
        if (!rst_n)
            base_q <= BASE_RST;
        else if (data_we && !is_start && st_q == INIT_BASE)
            base_q <= {wdata[W-1:ALIGN], {ALIGN{1'b0}}};
    end

    // Mask register: cleared by an init start, loaded by idle data writes.
    always_ff @(posedge clk) begin
        if (!rst_n)
            mask_q <= '1;
        else if (is_start)
            mask_q <= '0;
        else if (data_we && st_q == INIT_IDLE)
            mask_q <= wdata;
    end

    // Trigger-type register, written only through its own port.
    always_ff @(posedge clk) begin
        if (!rst_n)
            trig_q <= '0;
        else if (trig_we)
            trig_q <= wdata;
    end

    // In-service bits: retire the lowest one on EOI, then add new ones.
    always_ff @(posedge clk) begin
        if (!rst_n)
            isr_q <= '0;
        else
            isr_q <= (isr_q & ~eoi_clr) | svc_set;
    end

    assign busy = (st_q != INIT_IDLE);
endmodule

// File: rtl/cpic_vec.sv
// Turns a request index into a vector from the two controllers' bases.
// Assumes both controllers have W lines and W is a power of two.
module cpic_vec #(
    parameter int W     = cpic_pkg::DATA_W,
    parameter int IDX_W = cpic_pkg::IDX_W
) (
    input  logic [W-1:0]     base_lo,
    input  logic [W-1:0]     base_hi,
    input  logic [IDX_W-1:0] idx,
    output logic [W-1:0]     vec,
    output logic             invalid
);
    localparam int ALIGN = $clog2(W);
    localparam int TOTAL = 2 * W;

    logic          upper;
    logic [W-1:0]  offset;

    // Range check, controller select and base-plus-offset sum.
    always_comb begin
        invalid = (idx >= IDX_W'(TOTAL));
        upper   = (idx >= IDX_W'(W));
        offset  = W'(idx[ALIGN-1:0]);
        if (invalid)
            vec = '0;
        else
            vec = (upper ? base_hi : base_lo) + offset;
    end
endmodule

// File: rtl/cpic_regif.sv
// Top of the cascaded controller register front-end: decodes the bus,
// instantiates the two controllers, registers read data and translates
// request indices. Assumes a single-cycle, non-overlapping rd/wr bus.
module cpic_regif #(
    parameter int DATA_W = cpic_pkg::DATA_W,
    parameter int SEL_W  = cpic_pkg::SEL_W,
    parameter int IDX_W  = cpic_pkg::IDX_W,
    parameter int N_CTRL = cpic_pkg::N_CTRL
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [SEL_W-1:0]         bus_sel,
    input  logic                     bus_wr,
    input  logic                     bus_rd,
    input  logic [DATA_W-1:0]        bus_wdata,
    output logic [DATA_W-1:0]        bus_rdata,
    input  logic [N_CTRL*DATA_W-1:0] svc_set,
    output logic [N_CTRL*DATA_W-1:0] in_service,
    output logic [N_CTRL*DATA_W-1:0] irq_mask,
    output logic [N_CTRL*DATA_W-1:0] irq_level,
    output logic [N_CTRL-1:0]        init_busy,
    input  logic [IDX_W-1:0]         xlat_idx,
    output logic [DATA_W-1:0]        xlat_vec,
    output logic                     xlat_invalid
);
    import cpic_pkg::*;

    logic [DATA_W-1:0] base_arr [N_CTRL];
    logic [DATA_W-1:0] rd_next;

    for (genvar g = 0; g < N_CTRL; g++) begin : g_ctrl
        localparam logic [SEL_W-1:0] CMD_P  = (g == 0) ? PSEL_MCMD  : PSEL_SCMD;
        localparam logic [SEL_W-1:0] DATA_P = (g == 0) ? PSEL_MDATA : PSEL_SDATA;
        localparam logic [SEL_W-1:0] TRIG_P = (g == 0) ? PSEL_MTRIG : PSEL_STRIG;

        logic cmd_we;
        logic data_we;
        logic trig_we;

        // Per-controller write strobes from the shared bus.
        always_comb begin
            cmd_we  = bus_wr && (bus_sel == CMD_P);
            data_we = bus_wr && (bus_sel == DATA_P);
            trig_we = bus_wr && (bus_sel == TRIG_P);
        end

        cpic_ctrl #(.W(DATA_W)) u_ctrl (
            .clk     (clk),
            .rst_n   (rst_n),
            .cmd_we  (cmd_we),
            .data_we (data_we),
            .trig_we (trig_we),
            .wdata   (bus_wdata),
            .svc_set (svc_set[g*DATA_W +: DATA_W]),
            .mask_q  (irq_mask[g*DATA_W +: DATA_W]),
            .trig_q  (irq_level[g*DATA_W +: DATA_W]),
            .isr_q   (in_service[g*DATA_W +: DATA_W]),
            .base_q  (base_arr[g]),
            .busy    (init_busy[g])
        );
    end

    // Read multiplexer over the six ports.
    always_comb begin
        case (bus_sel)
            PSEL_MCMD:  rd_next = in_service[0 +: DATA_W];
            PSEL_MDATA: rd_next = irq_mask[0 +: DATA_W];
            PSEL_SCMD:  rd_next = in_service[DATA_W +: DATA_W];
            PSEL_SDATA: rd_next = irq_mask[DATA_W +: DATA_W];
            PSEL_MTRIG: rd_next = irq_level[0 +: DATA_W];
            PSEL_STRIG: rd_next = irq_level[DATA_W +: DATA_W];
            default:    rd_next = '0;
        endcase
    end

    // Read data register, updated only on a read strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)
            bus_rdata <= '0;
        else if (bus_rd)
            bus_rdata <= rd_next;
    end

    cpic_vec #(.W(DATA_W), .IDX_W(IDX_W)) u_vec (
        .base_lo (base_arr[0]),
        .base_hi (base_arr[1]),
        .idx     (xlat_idx),
        .vec     (xlat_vec),
        .invalid (xlat_invalid)
    );
endmodule

// File: rtl/cpic_regif_chk.sv
// Temporal checks on the register front-end, attached by bind.
// Assumes the default 8-line, two-controller configuration.
module cpic_regif_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [2:0]  bus_sel,
    input logic        bus_wr,
    input logic [7:0]  bus_wdata,
    input logic [15:0] svc_set,
    input logic [15:0] in_service,
    input logic [15:0] irq_mask,
    input logic [1:0]  init_busy,
    input logic        xlat_invalid,
    input logic [7:0]  xlat_vec
);
    AST_START_CLEARS_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_sel == 3'd0 && bus_wdata[4]) |=> (irq_mask[7:0] == 8'h00 && init_busy[0])); // R2

    AST_MASK_ZERO_IN_INIT: assert property (@(posedge clk) disable iff (!rst_n)
        init_busy[1] |-> irq_mask[15:8] == 8'h00); // R4

    AST_INVALID_ZERO_VEC: assert property (@(posedge clk) disable iff (!rst_n)
        xlat_invalid |-> xlat_vec == 8'h00); // R8

    AST_SVC_SETS_BITS: assert property (@(posedge clk) disable iff (!rst_n)
        (svc_set != 16'h0) |=> ((in_service & $past(svc_set)) == $past(svc_set))); // R9

    AST_EOI_CLEARS_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_sel == 3'd0 && bus_wdata == 8'h20 && svc_set == 16'h0 && in_service[7:0] != 8'h00)
        |=> ($countones(in_service[7:0]) + 1 == $countones($past(in_service[7:0])))); // R10

    AST_OTHER_CMD_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_sel == 3'd0 && !bus_wdata[4] && bus_wdata != 8'h20 && svc_set == 16'h0)
        |=> ($stable(in_service[7:0]) && $stable(irq_mask[7:0]))); // R11
endmodule

bind cpic_regif cpic_regif_chk chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .bus_sel      (bus_sel),
    .bus_wr       (bus_wr),
    .bus_wdata    (bus_wdata),
    .svc_set      (svc_set),
    .in_service   (in_service),
    .irq_mask     (irq_mask),
    .init_busy    (init_busy),
    .xlat_invalid (xlat_invalid),
    .xlat_vec     (xlat_vec)
);

// File: tb/cpic_regif_tb_top.sv
`timescale 1ns/1ps
module cpic_regif_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  bus_sel = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic [15:0] svc_set = '0;
    logic [15:0] in_service;
    logic [15:0] irq_mask;
    logic [15:0] irq_level;
    logic [1:0]  init_busy;
    logic [4:0]  xlat_idx = '0;
    logic [7:0]  xlat_vec;
    logic        xlat_invalid;

    int n_run  = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    cpic_regif dut_i (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .svc_set(svc_set),
        .in_service(in_service), .irq_mask(irq_mask), .irq_level(irq_level),
        .init_busy(init_busy), .xlat_idx(xlat_idx), .xlat_vec(xlat_vec),
        .xlat_invalid(xlat_invalid)
    );

    // Vector row: {req[23:20], is_read[19], sel[18:16], wdata[15:8], expected[7:0]}
    localparam int NV = 29;
    localparam logic [23:0] VECS [NV] = '{
        {4'd5,  1'b0, 3'd1, 8'hA5, 8'h00},  // R5 idle mask write
        {4'd5,  1'b1, 3'd1, 8'h00, 8'hA5},  // R5 read back
        {4'd2,  1'b0, 3'd0, 8'h11, 8'h00},  // R2 start, cascade + mode word
        {4'd4,  1'b1, 3'd1, 8'h00, 8'h00},  // R4 read during init
        {4'd3,  1'b0, 3'd1, 8'h6D, 8'h00},  // R3 base, low bits dropped -> 0x68
        {4'd3,  1'b0, 3'd1, 8'h04, 8'h00},  // R3 cascade word
        {4'd4,  1'b1, 3'd1, 8'h00, 8'h00},  // R4 still in init
        {4'd3,  1'b0, 3'd1, 8'h01, 8'h00},  // R3 mode word
        {4'd3,  1'b0, 3'd1, 8'h3C, 8'h00},  // R3 now a mask write
        {4'd3,  1'b1, 3'd1, 8'h00, 8'h3C},  // R3
        {4'd2,  1'b0, 3'd2, 8'h11, 8'h00},  // R2 secondary start
        {4'd3,  1'b0, 3'd3, 8'h75, 8'h00},  // R3 base -> 0x70
        {4'd3,  1'b0, 3'd3, 8'h02, 8'h00},  // R3 cascade id
        {4'd3,  1'b0, 3'd3, 8'h01, 8'h00},  // R3 mode word
        {4'd5,  1'b0, 3'd3, 8'hC3, 8'h00},  // R5 secondary mask
        {4'd5,  1'b1, 3'd3, 8'h00, 8'hC3},  // R5
        {4'd6,  1'b0, 3'd4, 8'h81, 8'h00},  // R6 primary trigger
        {4'd6,  1'b1, 3'd4, 8'h00, 8'h81},  // R6
        {4'd6,  1'b0, 3'd5, 8'h18, 8'h00},  // R6 secondary trigger
        {4'd6,  1'b1, 3'd5, 8'h00, 8'h18},  // R6
        {4'd3,  1'b0, 3'd0, 8'h13, 8'h00},  // R3 single + mode word
        {4'd3,  1'b0, 3'd1, 8'h40, 8'h00},  // R3 base 0x40
        {4'd3,  1'b0, 3'd1, 8'h01, 8'h00},  // R3 mode word
        {4'd3,  1'b0, 3'd1, 8'h55, 8'h00},  // R3 mask
        {4'd3,  1'b1, 3'd1, 8'h00, 8'h55},  // R3 two words consumed
        {4'd3,  1'b0, 3'd0, 8'h12, 8'h00},  // R3 single, no mode word
        {4'd3,  1'b0, 3'd1, 8'h68, 8'h00},  // R3 base 0x68
        {4'd3,  1'b0, 3'd1, 8'h0F, 8'h00},  // R3 mask
        {4'd3,  1'b1, 3'd1, 8'h00, 8'h0F}   // R3 one word consumed
    };

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [2:0] sel, input logic [7:0] d);
        @(negedge clk);
        bus_sel = sel; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [2:0] sel, output logic [7:0] d);
        @(negedge clk);
        bus_sel = sel; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic xlat(input logic [4:0] idx, input logic [7:0] exp_v, input logic exp_inv, input string req);
        @(negedge clk);
        xlat_idx = idx;
        #1;
        check(req, {7'd0, xlat_invalid, xlat_vec}, {7'd0, exp_inv, exp_v});
    endtask

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        logic [7:0] rd;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 mask", irq_mask, 16'hFFFF);
        check("R1 level", irq_level, 16'h0000);
        check("R1 in_service", in_service, 16'h0000);
        check("R1 busy", {14'd0, init_busy}, 16'h0000);
        xlat(5'd0, 8'hFF, 1'b0, "R1 vec idx0");
        xlat(5'd1, 8'h00, 1'b0, "R1 vec idx1 wrap");
        xlat(5'd9, 8'h00, 1'b0, "R1 vec idx9 wrap");

        for (int i = 0; i < NV; i++) begin
            if (VECS[i][19]) begin
                bus_read(VECS[i][18:16], rd);
                check($sformatf("R%0d row %0d", VECS[i][23:20], i), {8'd0, rd}, {8'd0, VECS[i][7:0]});
            end else begin
                bus_write(VECS[i][18:16], VECS[i][15:8]);
            end
        end

        check("R6 irq_level", irq_level, 16'h1881);
        check("R5 irq_mask", irq_mask, 16'hC30F);

        // R7 translation with primary base 0x68, secondary base 0x70
        xlat(5'd3,  8'h6B, 1'b0, "R7 idx3");
        xlat(5'd7,  8'h6F, 1'b0, "R7 idx7");
        xlat(5'd8,  8'h70, 1'b0, "R7 idx8");
        xlat(5'd12, 8'h74, 1'b0, "R7 idx12");
        xlat(5'd15, 8'h77, 1'b0, "R7 idx15");
        xlat(5'd16, 8'h00, 1'b1, "R8 idx16");
        xlat(5'd31, 8'h00, 1'b1, "R8 idx31");

        // R2 and R4 on the secondary: busy flag and cleared mask mid-sequence
        bus_write(3'd2, 8'h13);
        check("R2 busy", {14'd0, init_busy}, 16'h0002);
        check("R2 mask cleared", irq_mask, 16'h000F);
        bus_write(3'd3, 8'h70);
        bus_read(3'd3, rd);
        check("R4 read mid-init", {8'd0, rd}, 16'h0000);
        bus_write(3'd3, 8'h01);
        check("R3 busy drops", {14'd0, init_busy}, 16'h0000);
        bus_write(3'd3, 8'hC3);
        check("R3 mask restored", irq_mask, 16'hC30F);

        // R9 set in-service bits
        @(negedge clk);
        svc_set = 16'h0A06;
        @(negedge clk);
        svc_set = 16'h0000;
        check("R9 in_service", in_service, 16'h0A06);
        bus_read(3'd2, rd);
        check("R9 secondary isr read", {8'd0, rd}, 16'h000A);

        // R10 end of interrupt, secondary then primary
        bus_write(3'd2, 8'h20);
        check("R10 secondary eoi", in_service, 16'h0806);
        bus_write(3'd0, 8'h20);
        check("R10 primary eoi", in_service, 16'h0804);
        bus_read(3'd0, rd);
        check("R10 primary isr read", {8'd0, rd}, 16'h0004);

        // R11 unrelated command words
        bus_write(3'd0, 8'h0A);
        check("R11 isr unchanged", in_service, 16'h0804);
        check("R11 mask unchanged", irq_mask, 16'hC30F);
        bus_write(3'd2, 8'h60);
        check("R11 secondary isr unchanged", in_service, 16'h0804);

        // R10 empty controller
        bus_write(3'd0, 8'h20);
        check("R10 last primary bit", in_service, 16'h0800);
        bus_write(3'd0, 8'h20);
        check("R10 eoi on empty", in_service, 16'h0800);

        // R5 read data holds between reads
        repeat (2) @(negedge clk);
        check("R5 rdata held", {8'd0, bus_rdata}, 16'h0004);

        finish_run();
    end
endmodule